// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Blanking

This block turns a four-bit binary-coded-decimal value into the seven segment drives of a common-anode numeric display. The segment outputs are active-low: a 0 lights a segment. Values 0 to 9 show the decimal numerals. Values 10 to 15 each show a fixed non-numeric symbol, and none of them leaves the digit dark.

Three control inputs, all active-low, sit on top of the data path. The blanking input turns every segment off. The lamp-test input lights every segment. The ripple-blanking input suppresses a zero. A ripple-blanking output reports that a zero was suppressed. This lets digits be chained from the most significant digit downwards so that leading zeros vanish. The block is purely combinational.

Top module: `bcd7_decoder`

## Requirements
- R1: `seg_o` is ordered with bit 6 = segment a down to bit 0 = segment g, and a 0 lights a segment. With all controls inactive (high), the data codes map as follows: 0 -> 0000001, 1 -> 1001111, 2 -> 0010010, 3 -> 0000110, 4 -> 1001100, 5 -> 0100100, 8 -> 0000000.
- R2: Digit 6 has no top bar (1100000). Digit 7 lights only a, b and c (0001111). Digit 9 has no bottom bar (0001100).
- R3: Codes 10 to 15 give these patterns: 10 -> 1110010, 11 -> 1100110, 12 -> 1011100, 13 -> 0110100, 14 -> 1110000, 15 -> 1111110. None of them is all dark.
- R4: When `blank_ni` is high and `lt_ni` is low, `seg_o` is 0000000 whatever `bcd_i` and `rbi_ni` are, and `rbo_o` is high.
- R5: When `blank_ni` is low, `seg_o` is 1111111 whatever the other inputs are, and `rbo_o` is high. This input has the highest priority.
- R6: When `blank_ni` and `lt_ni` are high, `rbi_ni` is low and `bcd_i` is 0, `seg_o` is 1111111 and `rbo_o` is low.
- R7: In every case not covered by R6, `rbo_o` is high. A low `rbi_ni` with a non-zero `bcd_i` shows the normal pattern.
- R8: In a chain of digits, the top digit's `rbi_ni` is tied low, each lower digit's `rbi_ni` is fed from the `rbo_o` of the digit above, and the units digit's `rbi_ni` is tied high. In such a chain, leading zeros are dark. The first non-zero digit and every digit below it are shown, and a value of zero still shows a single 0 in the units place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bcd_i | input | 4 | Data nibble, bit 3 most significant |
| lt_ni | input | 1 | Lamp test, low lights all segments |
| rbi_ni | input | 1 | Ripple-blanking in, low suppresses a zero |
| blank_ni | input | 1 | Blanking in, low darkens all segments |
| seg_o | output | 7 | Segment drives a..g (bit 6..0), active-low |
| rbo_o | output | 1 | Low when this digit suppressed a zero |

## Verification
The checks assume that the four inputs are driven to known levels. Each check is therefore made only when none of them is unknown. The stimulus drives every input from time zero and changes the inputs only on falling clock edges, so no check sees an undriven value. The checks also assume that the chain wiring follows R8, and the bench builds its four-digit chain exactly that way.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
  localparam int unsigned BCD_W = 4;
  localparam int unsigned SEG_W = 7;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_DARK = '1;
  localparam seg_t SEG_FULL = '0;

  typedef enum logic [1:0] {
    DRV_DATA   = 2'd0,
    DRV_LAMP   = 2'd1,
    DRV_DARK   = 2'd2,
    DRV_RIPPLE = 2'd3
  } drv_e;
endpackage

// File: rtl/bcd7_zero_detect.sv
module bcd7_zero_detect
  import bcd7_pkg::*;
#(
  parameter int unsigned W = BCD_W
) (
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  assign zero_o = ~|val_i;
endmodule

// File: rtl/bcd7_glyph.sv
module bcd7_glyph
  import bcd7_pkg::*;
(
  input  bcd_t code_i,
  output seg_t glyph_o
);
  // abcdefg, bit 6 = a, 0 lights
  always_comb begin
    unique case (code_i)
      4'd0:  glyph_o = 7'b0000001;
      4'd1:  glyph_o = 7'b1001111;
      4'd2:  glyph_o = 7'b0010010;
      4'd3:  glyph_o = 7'b0000110;
      4'd4:  glyph_o = 7'b1001100;
      4'd5:  glyph_o = 7'b0100100;
      4'd6:  glyph_o = 7'b1100000;
      4'd7:  glyph_o = 7'b0001111;
      4'd8:  glyph_o = 7'b0000000;
      4'd9:  glyph_o = 7'b0001100;
      4'd10: glyph_o = 7'b1110010;
      4'd11: glyph_o = 7'b1100110;
      4'd12: glyph_o = 7'b1011100;
      4'd13: glyph_o = 7'b0110100;
      4'd14: glyph_o = 7'b1110000;
      default: glyph_o = 7'b1111110;
    endcase
  end
endmodule

// File: rtl/bcd7_override.sv
module bcd7_override
  import bcd7_pkg::*;
(
  input  seg_t glyph_i,
  input  logic zero_i,
  input  logic lt_ni,
  input  logic rbi_ni,
  input  logic blank_ni,
  output seg_t seg_o,
  output logic rbo_o
);
  drv_e mode;

  // priority: blank > lamp test > ripple zero > data
  always_comb begin
    if (!blank_ni)                mode = DRV_DARK;
    else if (!lt_ni)              mode = DRV_LAMP;
    else if (!rbi_ni && zero_i)   mode = DRV_RIPPLE;
    else                          mode = DRV_DATA;
  end

  for (genvar i = 0; i < SEG_W; i++) begin : g_seg
    always_comb begin
      unique case (mode)
        DRV_DATA: seg_o[i] = glyph_i[i];
        DRV_LAMP: seg_o[i] = SEG_FULL[i];
        default:  seg_o[i] = SEG_DARK[i];
      endcase
    end
  end

  assign rbo_o = (mode != DRV_RIPPLE);
endmodule

// File: rtl/bcd7_decoder.sv
module bcd7_decoder
  import bcd7_pkg::*;
(
  input  logic [BCD_W-1:0] bcd_i,
  input  logic             lt_ni,
  input  logic             rbi_ni,
  input  logic             blank_ni,
  output logic [SEG_W-1:0] seg_o,
  output logic             rbo_o
);
  seg_t glyph;
  logic zero;

  bcd7_glyph u_glyph (
    .code_i  (bcd_i),
    .glyph_o (glyph)
  );

  bcd7_zero_detect #(.W(BCD_W)) u_zero (
    .val_i  (bcd_i),
    .zero_o (zero)
  );

  bcd7_override u_ovr (
    .glyph_i  (glyph),
    .zero_i   (zero),
    .lt_ni    (lt_ni),
    .rbi_ni   (rbi_ni),
    .blank_ni (blank_ni),
    .seg_o    (seg_o),
    .rbo_o    (rbo_o)
  );
endmodule

// File: rtl/bcd7_decoder_chk.sv
module bcd7_decoder_chk
  import bcd7_pkg::*;
(
  input logic [BCD_W-1:0] bcd_i,
  input logic             lt_ni,
  input logic             rbi_ni,
  input logic             blank_ni,
  input logic [SEG_W-1:0] seg_o,
  input logic             rbo_o
);
  logic known;
  logic ripple_case;

  always_comb begin
    known       = !$isunknown({bcd_i, lt_ni, rbi_ni, blank_ni});
    ripple_case = blank_ni && lt_ni && !rbi_ni && (bcd_i == '0);
    if (known) begin
      a_r5_blank_all_off: assert (blank_ni || (seg_o == SEG_DARK && rbo_o));
      a_r4_lamp_all_on:   assert (!blank_ni || lt_ni || (seg_o == SEG_FULL && rbo_o));
      a_r6_ripple_dark:   assert (!ripple_case || (seg_o == SEG_DARK && !rbo_o));
      a_r7_rbo_high:      assert (ripple_case || rbo_o);
      a_r3_symbol_lit:    assert (!(blank_ni && lt_ni && bcd_i >= 4'd10) || seg_o != SEG_DARK);
      a_r2_six_no_top:    assert (!(blank_ni && lt_ni && bcd_i == 4'd6) || seg_o[6:5] == 2'b11);
    end
  end
endmodule

bind bcd7_decoder bcd7_decoder_chk u_chk (
  .bcd_i    (bcd_i),
  .lt_ni    (lt_ni),
  .rbi_ni   (rbi_ni),
  .blank_ni (blank_ni),
  .seg_o    (seg_o),
  .rbo_o    (rbo_o)
);

// File: tb/tb_bcd7_decoder.sv
module tb_bcd7_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [3:0] bcd = 4'd0;
  logic lt_n = 1'b1, rbi_n = 1'b1, bl_n = 1'b1;
  logic [6:0] seg;
  logic rbo;

  bcd7_decoder dut (
    .bcd_i (bcd), .lt_ni (lt_n), .rbi_ni (rbi_n), .blank_ni (bl_n),
    .seg_o (seg), .rbo_o (rbo)
  );

  // four-digit chain, d3 most significant
  logic [3:0] cb3 = 4'd0, cb2 = 4'd0, cb1 = 4'd0, cb0 = 4'd0;
  logic [6:0] cs3, cs2, cs1, cs0;
  logic cr3, cr2, cr1, cr0;
  bcd7_decoder u_d3 (.bcd_i(cb3), .lt_ni(1'b1), .rbi_ni(1'b0), .blank_ni(1'b1), .seg_o(cs3), .rbo_o(cr3));
  bcd7_decoder u_d2 (.bcd_i(cb2), .lt_ni(1'b1), .rbi_ni(cr3),  .blank_ni(1'b1), .seg_o(cs2), .rbo_o(cr2));
  bcd7_decoder u_d1 (.bcd_i(cb1), .lt_ni(1'b1), .rbi_ni(cr2),  .blank_ni(1'b1), .seg_o(cs1), .rbo_o(cr1));
  bcd7_decoder u_d0 (.bcd_i(cb0), .lt_ni(1'b1), .rbi_ni(1'b1), .blank_ni(1'b1), .seg_o(cs0), .rbo_o(cr0));

  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'd0: return 7'b0000001;  4'd1: return 7'b1001111;
      4'd2: return 7'b0010010;  4'd3: return 7'b0000110;
      4'd4: return 7'b1001100;  4'd5: return 7'b0100100;
      4'd6: return 7'b1100000;  4'd7: return 7'b0001111;
      4'd8: return 7'b0000000;  4'd9: return 7'b0001100;
      4'd10: return 7'b1110010; 4'd11: return 7'b1100110;
      4'd12: return 7'b1011100; 4'd13: return 7'b0110100;
      4'd14: return 7'b1110000; default: return 7'b1111110;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v, input logic lt, input logic rbi, input logic bl);
    @(negedge clk);
    bcd = v; lt_n = lt; rbi_n = rbi; bl_n = bl;
    #2;
  endtask

  task automatic t_idle;
    #2;
    chk("R1 idle zero", {seg, rbo}, {7'b0000001, 1'b1});
  endtask

  task automatic t_digits;
    for (int v = 0; v < 10; v++) begin
      drive(v[3:0], 1'b1, 1'b1, 1'b1);
      if (v == 6 || v == 7 || v == 9)
        chk("R2 special digit", {seg, rbo}, {glyph(v[3:0]), 1'b1});
      else
        chk("R1 digit", {seg, rbo}, {glyph(v[3:0]), 1'b1});
    end
  endtask

  task automatic t_symbols;
    for (int v = 10; v < 16; v++) begin
      drive(v[3:0], 1'b1, 1'b1, 1'b1);
      chk("R3 symbol", {seg, rbo}, {glyph(v[3:0]), 1'b1});
      chk("R3 not dark", {7'd0, seg == 7'h7f}, 8'd0);
    end
  endtask

  task automatic t_lamp;
    drive(4'd0, 1'b0, 1'b0, 1'b1);
    chk("R4 lamp over ripple zero", {seg, rbo}, 8'b0000000_1);
    drive(4'd15, 1'b0, 1'b1, 1'b1);
    chk("R4 lamp code 15", {seg, rbo}, 8'b0000000_1);
  endtask

  task automatic t_blank;
    drive(4'd8, 1'b0, 1'b1, 1'b0);
    chk("R5 blank over lamp", {seg, rbo}, 8'b1111111_1);
    drive(4'd0, 1'b1, 1'b0, 1'b0);
    chk("R5 blank zero rbi low", {seg, rbo}, 8'b1111111_1);
  endtask

  task automatic t_ripple;
    drive(4'd0, 1'b1, 1'b0, 1'b1);
    chk("R6 ripple zero", {seg, rbo}, 8'b1111111_0);
    drive(4'd3, 1'b1, 1'b0, 1'b1);
    chk("R7 ripple nonzero", {seg, rbo}, {glyph(4'd3), 1'b1});
    drive(4'd0, 1'b1, 1'b1, 1'b1);
    chk("R7 zero shown rbi high", {seg, rbo}, {glyph(4'd0), 1'b1});
  endtask

  task automatic t_exhaustive;
    for (int c = 0; c < 128; c++) begin
      logic [3:0] v;
      logic lt, rbi, bl, rb;
      logic [6:0] es;
      v = c[3:0]; lt = c[4]; rbi = c[5]; bl = c[6];
      drive(v, lt, rbi, bl);
      if (!bl) es = 7'h7f;
      else if (!lt) es = 7'h00;
      else if (!rbi && v == 4'd0) es = 7'h7f;
      else es = glyph(v);
      rb = !(bl && lt && !rbi && v == 4'd0);
      chk("R7 full sweep", {seg, rbo}, {es, rb});
    end
  endtask

  task automatic chain_case(input logic [3:0] d3, input logic [3:0] d2,
                            input logic [3:0] d1, input logic [3:0] d0);
    logic lead;
    logic [6:0] e3, e2, e1;
    @(negedge clk);
    cb3 = d3; cb2 = d2; cb1 = d1; cb0 = d0;
    #2;
    lead = 1'b1;
    e3 = (lead && d3 == 0) ? 7'h7f : glyph(d3); lead = lead && d3 == 0;
    e2 = (lead && d2 == 0) ? 7'h7f : glyph(d2); lead = lead && d2 == 0;
    e1 = (lead && d1 == 0) ? 7'h7f : glyph(d1);
    chk("R8 chain d3", {1'b0, cs3}, {1'b0, e3});
    chk("R8 chain d2", {1'b0, cs2}, {1'b0, e2});
    chk("R8 chain d1", {1'b0, cs1}, {1'b0, e1});
    chk("R8 chain d0", {1'b0, cs0}, {1'b0, glyph(d0)});
  endtask

  task automatic t_chain;
    chain_case(4'd0, 4'd0, 4'd0, 4'd0);
    chain_case(4'd0, 4'd0, 4'd4, 4'd0);
    chain_case(4'd1, 4'd0, 4'd0, 4'd5);
    chain_case(4'd0, 4'd7, 4'd0, 4'd0);
    chain_case(4'd0, 4'd0, 4'd0, 4'd9);
  endtask

  initial begin
    t_idle();
    t_digits();
    t_symbols();
    t_lamp();
    t_blank();
    t_ripple();
    t_exhaustive();
    t_chain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog got=%0d exp<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule